// File: doc/BRIEF.md
# Bit-Slice ALU with Stuck-At Fault Injection

A four-bit combinational ALU built from identical one-bit slices. Each slice decodes the two-bit function code into a one-hot set of function enables. Every function unit gates its output with its own enable, and the slice ORs all gated outputs into its result bit. The carry ripples from slice 0 up to slice 3. The supported functions are bitwise AND, bitwise OR, bitwise NOT of operand A, and addition with carry-in.

For checking how complete a vector suite is, a fault port can hold any one of the block's internal nets at a chosen value. The nets are each slice's operand bits, incoming carry and result bit, plus its four function enables. A bench applies a suite with a fault active and records whether any vector shows a difference at the primary outputs. A suite that leaves a fault unseen has a gap.

Top module: `alu_fi_top`

## Requirements
- R1: With `fsel` = 0 and no fault, `res` equals `opa & opb`.
- R2: With `fsel` = 1 and no fault, `res` equals `opa | opb`.
- R3: With `fsel` = 2 and no fault, `res` equals `~opa`.
- R4: With `fsel` = 3 and no fault, `{cout,res}` equals `opa + opb + cin`.
- R5: `cout` is 0 whenever `fsel` is not 3, with or without a fault.
- R6: While `fi_en` is 0, `fi_net` and `fi_val` have no effect on `res` or `cout`.
- R7: Net number `fi_net` = 8*k + j selects slice k. The local index j selects the net: 0 operand A bit, 1 operand B bit, 2 incoming carry, 3 result bit, 4 AND enable, 5 OR enable, 6 NOT enable, 7 add enable. While `fi_en` is 1, that net is held at `fi_val`, and its effect spreads through the downstream logic and the carry chain.
- R8: A held result bit (j = 3) forces `res[k]` to `fi_val`.
- R9: Holding slice k's add enable at 1 makes `res[k]` the decoded function's bit ORed with sum bit k. With equal operands and `cin` = 0, this fault on slice 0 cannot be seen. A vector with `opa[0]` different from `opb[0]` under `fsel` = 0 exposes it.
- R10: Holding the enable of the selected function at 0 drops slice k's result bit to 0.
- R11: A held carry into slice k (j = 2) alters only the sum from bit k upward and `cout`. It has no effect on the logic functions.
- R12: Applying every input combination exposes each of the 64 single stuck-at faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| fsel | input | 2 | Function code: 0 AND, 1 OR, 2 NOT A, 3 add |
| cin | input | 1 | Carry into slice 0 |
| fi_en | input | 1 | Fault injection active |
| fi_net | input | 5 | Number of the net to hold (8*slice + local index) |
| fi_val | input | 1 | Value the selected net is held at |
| res | output | 4 | Result |
| cout | output | 1 | Carry out of slice 3 when adding, else 0 |

## Verification
Without faults, the bench sweeps all 2048 operand, function and carry combinations. This separates the four function codes and exercises the carry chain from both carry-in values. Random vectors with random faults compare each output against a bench model of the faulted netlist, which confirms the net numbering. The bench then grades two suites against all 64 stuck-at faults. The full sweep must expose every fault. The equal-operand suite must miss the stuck add enable on slice 0, and one unequal vector must catch it.

// File: rtl/alu_fi_pkg.sv
package alu_fi_pkg;

  localparam int NETS_PER_SLICE = 8;

  // local net numbers inside one slice
  localparam int LN_A      = 0;
  localparam int LN_B      = 1;
  localparam int LN_CIN    = 2;
  localparam int LN_RES    = 3;
  localparam int LN_EN_AND = 4;
  localparam int LN_EN_OR  = 5;
  localparam int LN_EN_NOT = 6;
  localparam int LN_EN_ADD = 7;

  typedef enum logic [1:0] {
    FN_AND = 2'd0,
    FN_OR  = 2'd1,
    FN_NOT = 2'd2,
    FN_ADD = 2'd3
  } fn_e;

  typedef struct packed {
    logic en_and;
    logic en_or;
    logic en_not;
    logic en_add;
  } fn_en_t;

  // Replace a net value by the stuck value when the fault targets it
  function automatic logic stick(input logic v, input logic act,
                                 input int unsigned net, input int unsigned id,
                                 input logic sv);
    return (act && (net == id)) ? sv : v;
  endfunction

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/alu_fi_decoder.sv
module alu_fi_decoder
  import alu_fi_pkg::*;
(
  input  logic [1:0] fsel,
  output fn_en_t     en
);
  always_comb begin
    en = '0;
    unique case (fn_e'(fsel))
      FN_AND: en.en_and = 1'b1;
      FN_OR:  en.en_or  = 1'b1;
      FN_NOT: en.en_not = 1'b1;
      FN_ADD: en.en_add = 1'b1;
      default: en = '0;
    endcase
  end
endmodule

// File: rtl/alu_fi_adder.sv
module alu_fi_adder
  import alu_fi_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic ci,
  input  logic en,
  output logic sum_g,
  output logic co
);
  // the carry always ripples; only the sum is gated by the enable
  assign sum_g = en & fa_sum(a, b, ci);
  assign co    = fa_carry(a, b, ci);
endmodule

// File: rtl/alu_fi_logic.sv
module alu_fi_logic
  import alu_fi_pkg::*;
(
  input  logic   a,
  input  logic   b,
  input  fn_en_t en,
  output logic   y
);
  logic and_g, or_g, not_g;
  assign and_g = en.en_and & (a & b);
  assign or_g  = en.en_or  & (a | b);
  assign not_g = en.en_not & ~a;
  assign y     = and_g | or_g | not_g;
endmodule

// File: rtl/alu_fi_slice.sv
module alu_fi_slice
  import alu_fi_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int NET_W = 5
) (
  input  logic             a,
  input  logic             b,
  input  logic             ci,
  input  logic [1:0]       fsel,
  input  logic             fi_en,
  input  logic [NET_W-1:0] fi_net,
  input  logic             fi_val,
  output logic             r,
  output logic             co,
  output fn_en_t           en_eff
);
  localparam int BASE = IDX * NETS_PER_SLICE;

  int unsigned net_u;
  assign net_u = int'(fi_net);

  logic   a_f, b_f, ci_f;
  fn_en_t en_dec;
  logic   sum_g, log_y, r_raw;

  assign a_f  = stick(a,  fi_en, net_u, BASE + LN_A,   fi_val);
  assign b_f  = stick(b,  fi_en, net_u, BASE + LN_B,   fi_val);
  assign ci_f = stick(ci, fi_en, net_u, BASE + LN_CIN, fi_val);

  alu_fi_decoder u_dec (.fsel(fsel), .en(en_dec));

  assign en_eff.en_and = stick(en_dec.en_and, fi_en, net_u, BASE + LN_EN_AND, fi_val);
  assign en_eff.en_or  = stick(en_dec.en_or,  fi_en, net_u, BASE + LN_EN_OR,  fi_val);
  assign en_eff.en_not = stick(en_dec.en_not, fi_en, net_u, BASE + LN_EN_NOT, fi_val);
  assign en_eff.en_add = stick(en_dec.en_add, fi_en, net_u, BASE + LN_EN_ADD, fi_val);

  alu_fi_adder u_add (
    .a(a_f), .b(b_f), .ci(ci_f), .en(en_eff.en_add),
    .sum_g(sum_g), .co(co)
  );

  alu_fi_logic u_log (.a(a_f), .b(b_f), .en(en_eff), .y(log_y));

  assign r_raw = sum_g | log_y;
  assign r     = stick(r_raw, fi_en, net_u, BASE + LN_RES, fi_val);
endmodule

// File: rtl/alu_fi_top.sv
module alu_fi_top
  import alu_fi_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int NET_W = $clog2(WIDTH * NETS_PER_SLICE)
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       fsel,
  input  logic             cin,
  input  logic             fi_en,
  input  logic [NET_W-1:0] fi_net,
  input  logic             fi_val,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  logic [WIDTH:0]   chain;
  fn_en_t           en_eff [WIDTH];
  logic             add_sel;

  assign chain[0] = cin;

  for (genvar k = 0; k < WIDTH; k++) begin : g_slice
    alu_fi_slice #(.IDX(k), .NET_W(NET_W)) u_slice (
      .a(opa[k]), .b(opb[k]), .ci(chain[k]), .fsel(fsel),
      .fi_en(fi_en), .fi_net(fi_net), .fi_val(fi_val),
      .r(res[k]), .co(chain[k+1]), .en_eff(en_eff[k])
    );
  end

  assign add_sel = (fn_e'(fsel) == FN_ADD);
  assign cout    = add_sel & chain[WIDTH];
endmodule

// File: rtl/alu_fi_chk.sv
module alu_fi_chk
  import alu_fi_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int NET_W = 5
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [1:0]       fsel,
  input logic             cin,
  input logic             fi_en,
  input logic [NET_W-1:0] fi_net,
  input logic             fi_val,
  input logic [WIDTH-1:0] res,
  input logic             cout
);
  logic [WIDTH:0] total;
  int unsigned    k;
  int unsigned    j;

  always_comb begin
    total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
    k = int'(fi_net) / NETS_PER_SLICE;
    j = int'(fi_net) % NETS_PER_SLICE;

    if (!fi_en) begin
      if (fsel == 2'd0) p_and_r1: assert (res == (opa & opb));
      if (fsel == 2'd1) p_or_r2:  assert (res == (opa | opb));
      if (fsel == 2'd2) p_not_r3: assert (res == ~opa);
      if (fsel == 2'd3) p_add_r4: assert ({cout, res} == total);
    end
    if (fsel != 2'd3) p_cout_gate_r5: assert (cout == 1'b0);
    if (fi_en && k < WIDTH && j == LN_RES)
      p_res_stuck_r8: assert (res[k] == fi_val);
    if (fi_en && fi_val && k < WIDTH && j == LN_EN_ADD && fsel == 2'd0)
      p_add_en_or_r9: assert (res[k] == ((opa[k] & opb[k]) | total[k]));
    if (fi_en && k < WIDTH && j == LN_CIN && fsel == 2'd1)
      p_cin_no_logic_r11: assert (res == (opa | opb));
  end
endmodule

bind alu_fi_top alu_fi_chk #(.WIDTH(WIDTH), .NET_W(NET_W)) u_chk (
  .opa(opa), .opb(opb), .fsel(fsel), .cin(cin), .fi_en(fi_en),
  .fi_net(fi_net), .fi_val(fi_val), .res(res), .cout(cout)
);

// File: tb/sim_alu_fi_top.sv
module sim_alu_fi_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int NW = 5;
  localparam int NNETS = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  opa, opb, res;
  logic [1:0]    fsel;
  logic          cin, fi_en, fi_val, cout;
  logic [NW-1:0] fi_net;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu_fi_top u0 (
    .opa(opa), .opb(opb), .fsel(fsel), .cin(cin), .fi_en(fi_en),
    .fi_net(fi_net), .fi_val(fi_val), .res(res), .cout(cout)
  );

  // fault-free expectation written from the function table
  function automatic logic [W:0] ref_clean(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [1:0] f, input logic c);
    case (f)
      2'd0: return {1'b0, a & b};
      2'd1: return {1'b0, a | b};
      2'd2: return {1'b0, ~a};
      default: return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    endcase
  endfunction

  // expectation with one net held, walked bit by bit over the slice nets
  function automatic logic [W:0] ref_fault(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [1:0] f, input logic c,
                                           input logic act, input int net, input logic sv);
    logic [W-1:0] r;
    logic carry;
    carry = c;
    for (int k = 0; k < W; k++) begin
      logic ak, bk, ck, e_and, e_or, e_not, e_add, rk;
      ak = (act && net == 8*k+0) ? sv : a[k];
      bk = (act && net == 8*k+1) ? sv : b[k];
      ck = (act && net == 8*k+2) ? sv : carry;
      e_and = (act && net == 8*k+4) ? sv : (f == 2'd0);
      e_or  = (act && net == 8*k+5) ? sv : (f == 2'd1);
      e_not = (act && net == 8*k+6) ? sv : (f == 2'd2);
      e_add = (act && net == 8*k+7) ? sv : (f == 2'd3);
      rk = (e_and && ak && bk) || (e_or && (ak || bk)) || (e_not && !ak)
           || (e_add && (ak ^ bk ^ ck));
      r[k] = (act && net == 8*k+3) ? sv : rk;
      carry = (ak && bk) || (ck && (ak || bk));
    end
    return {(f == 2'd3) ? carry : 1'b0, r};
  endfunction

  task automatic chk(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h f=%0d c=%0d fi=%0d net=%0d v=%0d)",
               req, got, exp, opa, opb, fsel, cin, fi_en, fi_net, fi_val);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] f,
                       input logic c, input logic act, input int net, input logic sv);
    opa = a; opb = b; fsel = f; cin = c;
    fi_en = act; fi_net = NW'(net); fi_val = sv;
    #2;
  endtask

  string tag;

  initial begin
    void'($urandom(32'h1F2E));
    apply('0, '0, 2'd0, 1'b0, 1'b0, 0, 1'b0);
    chk("R1 idle state", {cout, res}, '0);

    // exhaustive fault-free sweep
    for (int v = 0; v < 2048; v++) begin
      logic [W-1:0] a, b; logic [1:0] f; logic c;
      a = v[3:0]; b = v[7:4]; f = v[9:8]; c = v[10];
      apply(a, b, f, c, 1'b0, 0, 1'b0);
      case (f)
        2'd0: tag = "R1";
        2'd1: tag = "R2";
        2'd2: tag = "R3";
        default: tag = "R4";
      endcase
      chk(tag, {cout, res}, ref_clean(a, b, f, c));
      if (f != 2'd3) chk("R5 cout gated", {4'b0, cout}, '0);
    end

    // R6: fault port values ignored while disabled
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] a, b; logic [1:0] f; logic c; int n;
      a = W'($urandom); b = W'($urandom); f = 2'($urandom); c = 1'($urandom);
      n = int'($urandom % NNETS);
      apply(a, b, f, c, 1'b0, n, 1'($urandom));
      chk("R6 disabled fault port", {cout, res}, ref_clean(a, b, f, c));
    end

    // directed fault cases
    apply(4'h0, 4'h0, 2'd0, 1'b0, 1'b1, 8*2+3, 1'b1);
    chk("R8 result bit2 stuck 1", {cout, res}, 5'h04);
    apply(4'hF, 4'hF, 2'd1, 1'b0, 1'b1, 8*1+3, 1'b0);
    chk("R8 result bit1 stuck 0", {cout, res}, 5'h0D);
    apply(4'h1, 4'h0, 2'd0, 1'b0, 1'b1, 7, 1'b1);
    chk("R9 slice0 add enable exposed", {cout, res}, 5'h01);
    apply(4'h5, 4'h5, 2'd0, 1'b0, 1'b1, 7, 1'b1);
    chk("R9 slice0 add enable hidden", {cout, res}, 5'h05);
    apply(4'hF, 4'hF, 2'd0, 1'b0, 1'b1, 8*3+4, 1'b0);
    chk("R10 AND enable slice3 stuck 0", {cout, res}, 5'h07);
    apply(4'h0, 4'h0, 2'd2, 1'b0, 1'b1, 8*0+6, 1'b0);
    chk("R10 NOT enable slice0 stuck 0", {cout, res}, 5'h0E);
    apply(4'h0, 4'h0, 2'd3, 1'b0, 1'b1, 8*1+2, 1'b1);
    chk("R11 carry into slice1 stuck 1", {cout, res}, 5'h02);
    apply(4'h7, 4'h1, 2'd3, 1'b0, 1'b1, 8*3+2, 1'b0);
    chk("R11 carry into slice3 stuck 0", {cout, res}, 5'h00);
    apply(4'h3, 4'h5, 2'd1, 1'b1, 1'b1, 8*2+2, 1'b1);
    chk("R11 carry fault ignored by OR", {cout, res}, 5'h07);
    apply(4'hA, 4'h0, 2'd2, 1'b0, 1'b1, 8*2+0, 1'b0);
    chk("R7 operand A slice2 stuck 0", {cout, res}, 5'h05);

    // random vectors with random faults
    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] a, b; logic [1:0] f; logic c, sv; int n;
      a = W'($urandom); b = W'($urandom); f = 2'($urandom); c = 1'($urandom);
      n = int'($urandom % NNETS); sv = 1'($urandom);
      apply(a, b, f, c, 1'b1, n, sv);
      chk("R7 random fault", {cout, res}, ref_fault(a, b, f, c, 1'b1, n, sv));
    end

    // grading: full sweep must expose every fault
    for (int n = 0; n < NNETS; n++) begin
      for (int s = 0; s < 2; s++) begin
        bit seen;
        seen = 1'b0;
        for (int v = 0; v < 2048; v++) begin
          logic [W-1:0] a, b; logic [1:0] f; logic c;
          a = v[3:0]; b = v[7:4]; f = v[9:8]; c = v[10];
          apply(a, b, f, c, 1'b1, n, 1'(s));
          chk("R7 faulted output", {cout, res}, ref_fault(a, b, f, c, 1'b1, n, 1'(s)));
          if ({cout, res} !== ref_clean(a, b, f, c)) seen = 1'b1;
        end
        chk("R12 fault exposed by full sweep", {4'b0, seen}, 5'h01);
      end
    end

    // grading: equal-operand suite misses slice0 add enable stuck 1
    begin
      bit seen;
      seen = 1'b0;
      for (int v = 0; v < 64; v++) begin
        logic [W-1:0] a; logic [1:0] f;
        a = v[3:0]; f = v[5:4];
        apply(a, a, f, 1'b0, 1'b1, 7, 1'b1);
        if ({cout, res} !== ref_clean(a, a, f, 1'b0)) seen = 1'b1;
      end
      chk("R9 equal-operand suite misses fault", {4'b0, seen}, 5'h00);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule